// File: doc/BRIEF.md
# Vector Operand Swizzle and Writemask Stage

This block prepares the operands of a four-component vector shader. Each cycle in which an instruction is issued, it looks up up to three source vectors by index. A source index can address the input file, the temporary file or the float constant file, and an address register may be added to it first. The stage then reorders each source's components under a per-source selector, may flip the sign of all four, and registers the three conditioned vectors for the arithmetic datapath that follows.

On the return path, a write-back port takes a result vector supplied from outside. The write enable mask and destination index decide which components land in the output file or the temporary file. An address-load variant of the write-back instead turns the x and y components into the two integer address registers. Components are opaque 24-bit floats (sign in bit 23, 7-bit exponent biased by 63 in bits 22:16, 16-bit fraction below). The only numeric operation is the float-to-integer conversion done by the address load.

Constants and inputs are filled through a load port. The output file can be read back through a read port, and temporaries are observed by naming them as sources.

Top module: `vsw_operand_stage`

## Requirements
- R1: Vectors carry component x in bits 23:0, then y, z and w upward. In the 27-bit descriptor, source 1 uses bits 8:0, source 2 uses bits 17:9 and source 3 uses bits 26:18. Within each 9-bit group, bits 2c+1:2c select which input component (0=x, 1=y, 2=z, 3=w) feeds result component c.
- R2: Bit 8 of a source's descriptor group is its negate flag. When it is set, bit 23 of all four selected components is toggled and nothing else changes, so a zero becomes 0x800000.
- R3: Write-back writes component c only when bit c of `wb_mask` is 1 (bit 0 is x). Components whose mask bit is clear keep their previous value.
- R4: With `wb_mova` low, destinations 0x00 to 0x0F write the output file and 0x10 to 0x1F write temporary (dest minus 0x10). Destinations 0x20 and above change neither file.
- R5: Address select 0 or 3 adds nothing to a source index. Select 1 adds address register 0 and select 2 adds address register 1. The sum is taken modulo 128.
- R6: With `iss_inv` low the offset applies to source 1 only. With it high the offset applies to source 2 only. Source 3 is never offset.
- R7: A write-back with `wb_mova` high loads address register 0 from component x when mask bit 0 is set, and register 1 from y when mask bit 1 is set. The value is truncated toward zero and saturated to ±127. Neither register file is written.
- R8: An effective source index of 0x00 to 0x0F reads the input file and 0x10 to 0x1F reads the temporary file. 0x20 to 0x20+UNIF_N-1 reads the constant file. Any higher index returns an all-zero vector.
- R9: Conditioned sources appear on `src*_o` with `src_vld_o` high one cycle after `iss_valid`, and hold otherwise. A write-back or address load in the issue cycle does not affect that issue's operands; the next issue sees it.
- R10: After reset every file, both address registers and all source outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Load a vector into the input or constant file |
| ld_uni | input | 1 | 1 selects the constant file, 0 the input file |
| ld_idx | input | 4 | Entry to load (constants ignore indices at or above UNIF_N) |
| ld_data | input | 96 | Vector to load |
| iss_valid | input | 1 | Issue an operand fetch this cycle |
| iss_idx1 | input | 7 | Source 1 index |
| iss_idx2 | input | 7 | Source 2 index |
| iss_idx3 | input | 7 | Source 3 index |
| iss_asel | input | 2 | Address register select |
| iss_inv | input | 1 | Inverted-operand instruction: offset goes to source 2 |
| iss_desc | input | 27 | Selector and negate descriptor |
| wb_en | input | 1 | Write-back strobe |
| wb_mova | input | 1 | Write-back loads the address registers instead |
| wb_dest | input | 7 | Destination index |
| wb_mask | input | 4 | Component write enables |
| wb_data | input | 96 | Result vector from the datapath |
| ord_idx | input | 4 | Output file read index |
| ord_data | output | 96 | Output file entry, combinational |
| src_vld_o | output | 1 | Conditioned sources valid |
| src1_o | output | 96 | Conditioned source 1 |
| src2_o | output | 96 | Conditioned source 2 |
| src3_o | output | 96 | Conditioned source 3 |

## Verification
Two cases can fall in the same cycle. An issue may read a temporary that the write-back is storing. An issue may use an address register that an address load is replacing. The bench drives the issue and the write-back in one cycle for each case. It expects the operands to reflect the state before the edge, and the next issue to reflect the new value. The reference model keeps its own files and address registers. It computes each issue's expectation before the clock edge and applies write-backs after it, so that ordering is the reference.

// File: rtl/vsw_pkg.sv
package vsw_pkg;

    localparam int COMP_W  = 24;
    localparam int NCOMP   = 4;
    localparam int SEL_W   = 2;
    localparam int IDX_W   = 7;
    localparam int FILE_N  = 16;
    localparam int FILE_IW = $clog2(FILE_N);
    localparam int VEC_W   = NCOMP * COMP_W;
    localparam int MOD_W   = NCOMP * SEL_W + 1;
    localparam int NSRC    = 3;
    localparam int DESC_W  = NSRC * MOD_W;
    localparam int TMP_BASE = FILE_N;
    localparam int UNI_BASE = 2 * FILE_N;
    localparam int EXP_BIAS = 63;

    typedef logic [NCOMP-1:0][COMP_W-1:0] vec_t;

    typedef struct packed {
        logic                        neg;
        logic [NCOMP-1:0][SEL_W-1:0] sel;
    } src_mod_t;

    typedef enum logic [1:0] {
        RT_IN   = 2'd0,
        RT_TMP  = 2'd1,
        RT_UNI  = 2'd2,
        RT_NONE = 2'd3
    } rtype_t;

    function automatic rtype_t classify(input logic [IDX_W-1:0] idx, input int unif_n);
        int v;
        v = int'(idx);
        if (v < TMP_BASE)
            return RT_IN;
        else if (v < UNI_BASE)
            return RT_TMP;
        else if (v < UNI_BASE + unif_n)
            return RT_UNI;
        else
            return RT_NONE;
    endfunction

    // Truncating float-to-integer conversion with symmetric saturation
    function automatic int f24_to_int(input logic [COMP_W-1:0] v, input int lim);
        int          e;
        int          sh;
        int          mag;
        logic [63:0] t;
        e   = int'(v[22:16]);
        mag = 0;
        if (e >= EXP_BIAS) begin
            sh = e - EXP_BIAS;
            if (sh > 40) begin
                mag = lim;
            end else begin
                t = {47'd0, 1'b1, v[15:0]} << sh;
                if (t[63:16] > 48'(lim))
                    mag = lim;
                else
                    mag = int'(t[47:16]);
            end
        end
        return v[23] ? -mag : mag;
    endfunction

endpackage

// File: rtl/vsw_vecfile.sv
module vsw_vecfile
    import vsw_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int RD_N  = 1,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [IW-1:0]            widx,
    input  logic [NCOMP-1:0]         wmask,
    input  vec_t                     wdata,
    input  logic [RD_N-1:0][IW-1:0]  ridx,
    output vec_t [RD_N-1:0]          rdata
);

    vec_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int e = 0; e < DEPTH; e++)
                mem[e] <= '0;
        end else if (we) begin
            for (int c = 0; c < NCOMP; c++)
                if (wmask[c])
                    mem[widx][c] <= wdata[c];
        end
    end

    for (genvar r = 0; r < RD_N; r++) begin : g_rd
        assign rdata[r] = mem[ridx[r]];
    end

    for (genvar e = 0; e < DEPTH; e++) begin : g_chk_e
        for (genvar c = 0; c < NCOMP; c++) begin : g_chk_c
            AST_MASKED_COMP_KEEPS: assert property (@(posedge clk) disable iff (rst)
                !(we && int'(widx) == e && wmask[c]) |=> $stable(mem[e][c])) // R3
                else $error("masked or unaddressed component changed");
        end
    end

endmodule

// File: rtl/vsw_swizzle.sv
module vsw_swizzle
    import vsw_pkg::*;
(
    input  vec_t     raw,
    input  src_mod_t mods,
    output vec_t     cooked
);

    always_comb begin
        for (int c = 0; c < NCOMP; c++) begin
            cooked[c]           = raw[mods.sel[c]];
            cooked[c][COMP_W-1] = raw[mods.sel[c]][COMP_W-1] ^ mods.neg;
        end
    end

endmodule

// File: rtl/vsw_areg.sv
module vsw_areg
    import vsw_pkg::*;
#(
    parameter int ADDR_W = 8,
    localparam int LIM   = (1 << (ADDR_W - 1)) - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mova_en,
    input  logic [1:0]        mova_mask,
    input  logic [COMP_W-1:0] x_val,
    input  logic [COMP_W-1:0] y_val,
    input  logic [1:0]        sel,
    output logic [ADDR_W-1:0] offset
);

    logic [ADDR_W-1:0] areg [2];
    int                conv [2];

    always_comb begin
        conv[0] = f24_to_int(x_val, LIM);
        conv[1] = f24_to_int(y_val, LIM);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            areg[0] <= '0;
            areg[1] <= '0;
        end else if (mova_en) begin
            for (int i = 0; i < 2; i++)
                if (mova_mask[i])
                    areg[i] <= conv[i][ADDR_W-1:0];
        end
    end

    always_comb begin
        unique case (sel)
            2'd1:    offset = areg[0];
            2'd2:    offset = areg[1];
            default: offset = '0;
        endcase
    end

    AST_AREG_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !mova_en |=> ($stable(areg[0]) && $stable(areg[1]))) // R7
        else $error("address register moved without load");

    AST_AREG_X_MASKED: assert property (@(posedge clk) disable iff (rst)
        (mova_en && !mova_mask[0]) |=> $stable(areg[0])) // R7
        else $error("address register 0 written while masked");

    AST_AREG_Y_MASKED: assert property (@(posedge clk) disable iff (rst)
        (mova_en && !mova_mask[1]) |=> $stable(areg[1])) // R7
        else $error("address register 1 written while masked");

endmodule

// File: rtl/vsw_operand_stage.sv
module vsw_operand_stage
    import vsw_pkg::*;
#(
    parameter int UNIF_N = 8,
    parameter int ADDR_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ld_en,
    input  logic                ld_uni,
    input  logic [3:0]          ld_idx,
    input  logic [95:0]         ld_data,
    input  logic                iss_valid,
    input  logic [6:0]          iss_idx1,
    input  logic [6:0]          iss_idx2,
    input  logic [6:0]          iss_idx3,
    input  logic [1:0]          iss_asel,
    input  logic                iss_inv,
    input  logic [26:0]         iss_desc,
    input  logic                wb_en,
    input  logic                wb_mova,
    input  logic [6:0]          wb_dest,
    input  logic [3:0]          wb_mask,
    input  logic [95:0]         wb_data,
    input  logic [3:0]          ord_idx,
    output logic [95:0]         ord_data,
    output logic                src_vld_o,
    output logic [95:0]         src1_o,
    output logic [95:0]         src2_o,
    output logic [95:0]         src3_o
);

    localparam int UIW = (UNIF_N > 1) ? $clog2(UNIF_N) : 1;

    // ---------------- address registers ----------------
    logic [ADDR_W-1:0] areg_off;
    logic [31:0]       off_ext;

    vsw_areg #(.ADDR_W(ADDR_W)) areg_i (
        .clk      (clk),
        .rst      (rst),
        .mova_en  (wb_en && wb_mova),
        .mova_mask(wb_mask[1:0]),
        .x_val    (wb_data[COMP_W-1:0]),
        .y_val    (wb_data[2*COMP_W-1:COMP_W]),
        .sel      (iss_asel),
        .offset   (areg_off)
    );

    assign off_ext = 32'(signed'(areg_off));

    // ---------------- index resolution ----------------
    logic [NSRC-1:0][IDX_W-1:0]   raw_idx;
    logic [NSRC-1:0][IDX_W-1:0]   eff_idx;
    logic [NSRC-1:0][IDX_W-1:0]   uni_rel;
    logic [NSRC-1:0]              use_off;
    rtype_t                       rtype [NSRC];
    logic [NSRC-1:0][FILE_IW-1:0] file_ridx;
    logic [NSRC-1:0][UIW-1:0]     uni_ridx;
    vec_t [NSRC-1:0]              in_rd;
    vec_t [NSRC-1:0]              tmp_rd;
    vec_t [NSRC-1:0]              uni_rd;
    vec_t                         fetched [NSRC];
    vec_t                         cooked  [NSRC];
    src_mod_t [NSRC-1:0]          mods;

    assign raw_idx = {iss_idx3, iss_idx2, iss_idx1};
    assign mods    = iss_desc;
    assign use_off = {1'b0, iss_inv, !iss_inv};

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        assign eff_idx[s]   = use_off[s] ? IDX_W'(32'(raw_idx[s]) + off_ext) : raw_idx[s];
        assign uni_rel[s]   = eff_idx[s] - IDX_W'(UNI_BASE);
        assign file_ridx[s] = eff_idx[s][FILE_IW-1:0];
        assign uni_ridx[s]  = uni_rel[s][UIW-1:0];
        assign rtype[s]     = classify(eff_idx[s], UNIF_N);

        always_comb begin
            unique case (rtype[s])
                RT_IN:   fetched[s] = in_rd[s];
                RT_TMP:  fetched[s] = tmp_rd[s];
                RT_UNI:  fetched[s] = uni_rd[s];
                default: fetched[s] = '0;
            endcase
        end

        vsw_swizzle swz_i (
            .raw   (fetched[s]),
            .mods  (mods[s]),
            .cooked(cooked[s])
        );
    end

    // ---------------- register files ----------------
    logic in_we, uni_we, out_we, tmp_we;

    assign in_we  = ld_en && !ld_uni;
    assign uni_we = ld_en && ld_uni && (int'(ld_idx) < UNIF_N);
    assign out_we = wb_en && !wb_mova && (int'(wb_dest) < TMP_BASE);
    assign tmp_we = wb_en && !wb_mova && (int'(wb_dest) >= TMP_BASE) && (int'(wb_dest) < UNI_BASE);

    vsw_vecfile #(.DEPTH(FILE_N), .RD_N(NSRC)) in_file_i (
        .clk(clk), .rst(rst),
        .we(in_we), .widx(ld_idx[FILE_IW-1:0]), .wmask('1), .wdata(ld_data),
        .ridx(file_ridx), .rdata(in_rd)
    );

    vsw_vecfile #(.DEPTH(UNIF_N), .RD_N(NSRC)) uni_file_i (
        .clk(clk), .rst(rst),
        .we(uni_we), .widx(ld_idx[UIW-1:0]), .wmask('1), .wdata(ld_data),
        .ridx(uni_ridx), .rdata(uni_rd)
    );

    vsw_vecfile #(.DEPTH(FILE_N), .RD_N(NSRC)) tmp_file_i (
        .clk(clk), .rst(rst),
        .we(tmp_we), .widx(wb_dest[FILE_IW-1:0]), .wmask(wb_mask), .wdata(wb_data),
        .ridx(file_ridx), .rdata(tmp_rd)
    );

    vec_t [0:0] ord_rd;

    vsw_vecfile #(.DEPTH(FILE_N), .RD_N(1)) out_file_i (
        .clk(clk), .rst(rst),
        .we(out_we), .widx(wb_dest[FILE_IW-1:0]), .wmask(wb_mask), .wdata(wb_data),
        .ridx(ord_idx), .rdata(ord_rd)
    );

    assign ord_data = ord_rd[0];

    // ---------------- operand register ----------------
    vec_t src_q [NSRC];
    logic vld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            for (int s = 0; s < NSRC; s++)
                src_q[s] <= '0;
        end else begin
            vld_q <= iss_valid;
            if (iss_valid)
                for (int s = 0; s < NSRC; s++)
                    src_q[s] <= cooked[s];
        end
    end

    assign src_vld_o = vld_q;
    assign src1_o    = src_q[0];
    assign src2_o    = src_q[1];
    assign src3_o    = src_q[2];

    // ---------------- assertions ----------------
    AST_ONE_FILE_WRITE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({out_we, tmp_we})) // R4
        else $error("both files written by one write-back");

    AST_HIGH_DEST_DROPS: assert property (@(posedge clk) disable iff (rst)
        (wb_en && int'(wb_dest) >= UNI_BASE) |-> !(out_we || tmp_we)) // R4
        else $error("high destination reached a file");

    AST_MOVA_NO_FILE: assert property (@(posedge clk) disable iff (rst)
        (wb_en && wb_mova) |-> !(out_we || tmp_we)) // R7
        else $error("address load wrote a register file");

    AST_SRC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !iss_valid |=> ($stable(src1_o) && $stable(src2_o) && $stable(src3_o))) // R9
        else $error("operands changed without issue");

endmodule

// File: tb/vsw_operand_stage_tb.sv
module vsw_operand_stage_tb_top;
    import vsw_pkg::*;

    localparam int UNIF_N = 8;
    localparam int ADDR_W = 8;
    localparam int LIM    = (1 << (ADDR_W - 1)) - 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_en = 0, ld_uni = 0;
    logic [3:0]  ld_idx = '0;
    logic [95:0] ld_data = '0;
    logic        iss_valid = 0, iss_inv = 0;
    logic [6:0]  iss_idx1 = '0, iss_idx2 = '0, iss_idx3 = '0;
    logic [1:0]  iss_asel = '0;
    logic [26:0] iss_desc = '0;
    logic        wb_en = 0, wb_mova = 0;
    logic [6:0]  wb_dest = '0;
    logic [3:0]  wb_mask = '0;
    logic [95:0] wb_data = '0;
    logic [3:0]  ord_idx = '0;
    logic [95:0] ord_data;
    logic        src_vld_o;
    logic [95:0] src1_o, src2_o, src3_o;

    always #10 clk = ~clk;

    vsw_operand_stage #(.UNIF_N(UNIF_N), .ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst(rst),
        .ld_en(ld_en), .ld_uni(ld_uni), .ld_idx(ld_idx), .ld_data(ld_data),
        .iss_valid(iss_valid), .iss_idx1(iss_idx1), .iss_idx2(iss_idx2), .iss_idx3(iss_idx3),
        .iss_asel(iss_asel), .iss_inv(iss_inv), .iss_desc(iss_desc),
        .wb_en(wb_en), .wb_mova(wb_mova), .wb_dest(wb_dest), .wb_mask(wb_mask), .wb_data(wb_data),
        .ord_idx(ord_idx), .ord_data(ord_data),
        .src_vld_o(src_vld_o), .src1_o(src1_o), .src2_o(src2_o), .src3_o(src3_o)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference state
    vec_t m_in  [16];
    vec_t m_tmp [16];
    vec_t m_out [16];
    vec_t m_uni [UNIF_N];
    int   m_a   [2];

    logic [287:0] exp_q [$];
    string        tag_q [$];
    string        cur_tag = "";

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [95:0] act, input logic [95:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    function automatic vec_t mkvec(input logic [23:0] x, input logic [23:0] y,
                                   input logic [23:0] z, input logic [23:0] w);
        return {w, z, y, x};
    endfunction

    function automatic logic [26:0] mkdesc(input logic [7:0] s1, input bit n1,
                                           input logic [7:0] s2, input bit n2,
                                           input logic [7:0] s3, input bit n3);
        return {n3, s3, n2, s2, n1, s1};
    endfunction

    function automatic vec_t swz_ref(input vec_t v, input logic [8:0] md);
        vec_t r;
        for (int c = 0; c < 4; c++) begin
            r[c] = v[md[2*c +: 2]];
            if (md[8]) r[c][23] = ~r[c][23];
        end
        return r;
    endfunction

    function automatic vec_t fetch_ref(input int idx);
        int i;
        i = idx & 127;
        if (i < 16) return m_in[i];
        if (i < 32) return m_tmp[i - 16];
        if (i < 32 + UNIF_N) return m_uni[i - 32];
        return '0;
    endfunction

    function automatic int f2i_ref(input logic [23:0] v);
        int  e;
        int  mag;
        real r;
        e = int'(v[22:16]);
        if (e < 63) begin
            mag = 0;
        end else begin
            r = (1.0 + real'(v[15:0]) / 65536.0) * (2.0 ** (e - 63));
            if (r >= real'(LIM)) mag = LIM;
            else mag = $rtoi(r);
        end
        return v[23] ? -mag : mag;
    endfunction

    // one clock: predict issue from pre-edge state, then apply writes
    task automatic step();
        if (iss_valid) begin
            int   off;
            vec_t e1, e2, e3;
            off = (iss_asel == 2'd1) ? m_a[0] : (iss_asel == 2'd2) ? m_a[1] : 0;
            e1 = swz_ref(fetch_ref(int'(iss_idx1) + (iss_inv ? 0 : off)), iss_desc[8:0]);
            e2 = swz_ref(fetch_ref(int'(iss_idx2) + (iss_inv ? off : 0)), iss_desc[17:9]);
            e3 = swz_ref(fetch_ref(int'(iss_idx3)), iss_desc[26:18]);
            exp_q.push_back({e3, e2, e1});
            tag_q.push_back(cur_tag);
        end
        @(posedge clk);
        if (ld_en) begin
            if (!ld_uni) m_in[ld_idx] = ld_data;
            else if (int'(ld_idx) < UNIF_N) m_uni[ld_idx] = ld_data;
        end
        if (wb_en) begin
            if (wb_mova) begin
                if (wb_mask[0]) m_a[0] = f2i_ref(wb_data[23:0]);
                if (wb_mask[1]) m_a[1] = f2i_ref(wb_data[47:24]);
            end else begin
                for (int c = 0; c < 4; c++) begin
                    if (wb_mask[c]) begin
                        if (wb_dest < 7'h10) m_out[wb_dest[3:0]][c] = wb_data[24*c +: 24];
                        else if (wb_dest < 7'h20) m_tmp[wb_dest[3:0]][c] = wb_data[24*c +: 24];
                    end
                end
            end
        end
        @(negedge clk);
        ld_en = 0; iss_valid = 0; wb_en = 0; wb_mova = 0; iss_inv = 0; iss_asel = '0;
    endtask

    task automatic set_issue(input logic [6:0] i1, input logic [6:0] i2, input logic [6:0] i3,
                             input logic [1:0] asel, input bit inv, input logic [26:0] desc,
                             input string tag);
        iss_valid = 1; iss_idx1 = i1; iss_idx2 = i2; iss_idx3 = i3;
        iss_asel = asel; iss_inv = inv; iss_desc = desc; cur_tag = tag;
    endtask

    task automatic set_wb(input bit mova, input logic [6:0] dest, input logic [3:0] mask,
                          input logic [95:0] data);
        wb_en = 1; wb_mova = mova; wb_dest = dest; wb_mask = mask; wb_data = data;
    endtask

    task automatic issue(input logic [6:0] i1, input logic [6:0] i2, input logic [6:0] i3,
                         input logic [1:0] asel, input bit inv, input logic [26:0] desc,
                         input string tag);
        set_issue(i1, i2, i3, asel, inv, desc, tag);
        step();
    endtask

    task automatic wb(input bit mova, input logic [6:0] dest, input logic [3:0] mask,
                      input logic [95:0] data);
        set_wb(mova, dest, mask, data);
        step();
    endtask

    task automatic check_out(input int idx, input string tag);
        ord_idx = 4'(idx);
        #1;
        check(ord_data === m_out[idx], tag, $sformatf("output file entry %0d", idx),
              ord_data, m_out[idx]);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && src_vld_o) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9", "unexpected operand valid", {95'd0, src_vld_o}, '0);
            end else begin
                logic [287:0] e;
                string        t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(src1_o === e[95:0],    t, "source 1", src1_o, e[95:0]);
                check(src2_o === e[191:96],  t, "source 2", src2_o, e[191:96]);
                check(src3_o === e[287:192], t, "source 3", src3_o, e[287:192]);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    localparam logic [7:0] SW_ID  = 8'hE4;
    localparam logic [7:0] SW_REV = 8'h1B;
    localparam logic [7:0] SW_YYY = 8'h55;
    localparam logic [7:0] SW_XXX = 8'h00;

    initial begin
        for (int k = 0; k < 16; k++) begin
            m_in[k] = '0; m_tmp[k] = '0; m_out[k] = '0;
        end
        for (int k = 0; k < UNIF_N; k++) m_uni[k] = '0;
        m_a[0] = 0; m_a[1] = 0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R10: reset state
        check(src_vld_o === 1'b0, "R10", "valid after reset", {95'd0, src_vld_o}, '0);
        check(src1_o === '0, "R10", "source 1 after reset", src1_o, '0);
        check_out(0, "R10");
        check_out(15, "R10");
        issue(7'h00, 7'h10, 7'h20, 2'd0, 0, mkdesc(SW_ID, 0, SW_ID, 0, SW_ID, 0), "R10");

        // fill inputs and constants
        for (int k = 0; k < 16; k++) begin
            ld_en = 1; ld_uni = 0; ld_idx = 4'(k);
            ld_data = mkvec({8'(k), 8'h00, 8'h5A}, {8'(k), 8'h01, 8'h5A},
                            {8'(k), 8'h02, 8'h5A}, {8'(k), 8'h03, 8'h5A});
            step();
        end
        for (int k = 0; k < UNIF_N; k++) begin
            ld_en = 1; ld_uni = 1; ld_idx = 4'(k);
            ld_data = mkvec({8'(8'hC0 + k), 8'h00, 8'hA5}, {8'(8'hC0 + k), 8'h01, 8'hA5},
                            {8'(8'hC0 + k), 8'h02, 8'hA5}, {8'(8'hC0 + k), 8'h03, 8'hA5});
            step();
        end

        // R1: selector patterns
        issue(7'h03, 7'h05, 7'h07, 2'd0, 0, mkdesc(SW_ID, 0, SW_REV, 0, SW_YYY, 0), "R1");
        issue(7'h09, 7'h21, 7'h0F, 2'd0, 0, mkdesc(SW_XXX, 0, SW_REV, 0, 8'h9C, 0), "R1");

        // R2: negation, including zero temporaries
        issue(7'h02, 7'h11, 7'h22, 2'd0, 0, mkdesc(SW_ID, 1, SW_ID, 1, SW_REV, 0), "R2");
        issue(7'h02, 7'h02, 7'h22, 2'd0, 0, mkdesc(SW_ID, 0, SW_YYY, 0, SW_REV, 1), "R2");

        // R3 and R4: masked temporary writes
        wb(0, 7'h12, 4'b1010, mkvec(24'h111111, 24'h222222, 24'h333333, 24'h444444));
        issue(7'h12, 7'h12, 7'h12, 2'd0, 0, mkdesc(SW_ID, 0, SW_REV, 0, SW_ID, 0), "R3");
        wb(0, 7'h12, 4'b0001, mkvec(24'h555555, 24'h666666, 24'h777777, 24'h888888));
        issue(7'h12, 7'h02, 7'h02, 2'd0, 0, mkdesc(SW_ID, 0, SW_ID, 0, SW_ID, 0), "R3");

        // R4: output file write, files stay separate
        wb(0, 7'h04, 4'b1111, mkvec(24'hABCDEF, 24'h123456, 24'h654321, 24'hFEDCBA));
        check_out(4, "R4");
        issue(7'h04, 7'h14, 7'h24, 2'd0, 0, mkdesc(SW_ID, 0, SW_ID, 0, SW_ID, 0), "R4");

        // R4: high destinations discarded
        wb(0, 7'h24, 4'b1111, mkvec(24'h0BAD01, 24'h0BAD02, 24'h0BAD03, 24'h0BAD04));
        wb(0, 7'h7F, 4'b1111, mkvec(24'h0BAD05, 24'h0BAD06, 24'h0BAD07, 24'h0BAD08));
        check_out(4, "R4");
        check_out(15, "R4");
        issue(7'h14, 7'h1F, 7'h24, 2'd0, 0, mkdesc(SW_ID, 0, SW_ID, 0, SW_ID, 0), "R4");

        // R7 and R5: address load, no file write
        wb(1, 7'h06, 4'b0011, mkvec(24'h408000, 24'hC00000, 24'h0, 24'h0));
        check_out(6, "R7");
        issue(7'h02, 7'h02, 7'h02, 2'd1, 0, mkdesc(SW_ID, 0, SW_ID, 0, SW_ID, 0), "R5");
        issue(7'h13, 7'h02, 7'h02, 2'd2, 0, mkdesc(SW_ID, 0, SW_ID, 0, SW_ID, 0), "R5");

        // R6: inverted-operand mode
        issue(7'h02, 7'h02, 7'h02, 2'd1, 1, mkdesc(SW_ID, 0, SW_ID, 0, SW_ID, 0), "R6");

        // R7: mask on address load
        wb(1, 7'h00, 4'b0010, mkvec(24'h480000, 24'h3F0000, 24'h0, 24'h0));
        issue(7'h00, 7'h00, 7'h00, 2'd1, 0, mkdesc(SW_ID, 0, SW_ID, 0, SW_ID, 0), "R7");
        issue(7'h00, 7'h00, 7'h00, 2'd2, 0, mkdesc(SW_ID, 0, SW_ID, 0, SW_ID, 0), "R7");

        // R7 saturation and truncation, R5 wrap
        wb(1, 7'h00, 4'b0011, mkvec(24'hC80000, 24'h3E0000, 24'h0, 24'h0));
        issue(7'h7F, 7'h28, 7'h01, 2'd1, 0, mkdesc(SW_ID, 0, SW_ID, 0, SW_ID, 0), "R7");
        issue(7'h22, 7'h20, 7'h01, 2'd2, 0, mkdesc(SW_ID, 0, SW_ID, 0, SW_ID, 0), "R7");
        issue(7'h05, 7'h20, 7'h01, 2'd1, 1, mkdesc(SW_ID, 0, SW_ID, 0, SW_ID, 0), "R5");

        // R8: decode edges
        issue(7'h27, 7'h28, 7'h40, 2'd0, 0, mkdesc(SW_ID, 0, SW_ID, 0, SW_ID, 0), "R8");
        issue(7'h0F, 7'h10, 7'h1F, 2'd0, 0, mkdesc(SW_ID, 0, SW_ID, 0, SW_ID, 0), "R8");

        // R9: write-back and read of the same temporary in one cycle
        set_wb(0, 7'h13, 4'b1111, mkvec(24'h13A001, 24'h13A002, 24'h13A003, 24'h13A004));
        set_issue(7'h13, 7'h13, 7'h02, 2'd0, 0, mkdesc(SW_ID, 0, SW_REV, 0, SW_ID, 0), "R9");
        step();
        issue(7'h13, 7'h13, 7'h02, 2'd0, 0, mkdesc(SW_ID, 0, SW_REV, 0, SW_ID, 0), "R9");

        // R9: address load and offset use in one cycle
        set_wb(1, 7'h00, 4'b0001, mkvec(24'h3F0000, 24'h0, 24'h0, 24'h0));
        set_issue(7'h00, 7'h03, 7'h03, 2'd1, 0, mkdesc(SW_ID, 0, SW_ID, 0, SW_ID, 0), "R9");
        step();
        issue(7'h00, 7'h03, 7'h03, 2'd1, 0, mkdesc(SW_ID, 0, SW_ID, 0, SW_ID, 0), "R9");

        // R5: select 3 adds nothing
        issue(7'h06, 7'h06, 7'h06, 2'd3, 0, mkdesc(SW_ID, 0, SW_ID, 0, SW_ID, 0), "R5");

        step();
        step();
        step();
        check(exp_q.size() == 0, "R9", "pending expected operands", 96'(exp_q.size()), '0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule